// File: doc/BRIEF.md
# Conditional ALU Execute Stage

This block is the execute step of a 32-bit load/store processor pipeline. Each clock it takes one instruction word, two already-fetched operands, the carry produced by the operand shifter and the current N, Z, C, V status flags. First it decides from the instruction's 4-bit condition field whether the instruction takes effect. Then it runs one of sixteen data-processing operations and works out the flags that the operation would produce.

Every output is registered. One clock edge after the inputs are presented, the block gives the operation result, a write-enable for the destination register and the flag word for the next instruction. When the instruction does not take effect, or when it does not ask for flag updates, the flag word that was presented is passed through unchanged. Register read and write, and the barrel shifter, are outside the block. The surrounding datapath feeds the shifted second operand and its carry-out into the block.

Top module: `cond_alu_stage`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `wr_en` and `flags_out` become zero on that edge.
- R2: The condition is `instr[31:28]`. `flags_in`/`flags_out` are packed as {N,Z,C,V} in bits 3..0. Codes 0..7 pass respectively when Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1. Code 10 passes when N equals V, and code 11 passes when they differ. Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R4: Code 14 always passes. Code 15 never passes, so `wr_en` stays low and the flags are not updated.
- R5: The opcode is `instr[24:21]`. Opcodes 0 AND, 1 XOR, 12 OR, 13 move `b`, 14 `a & ~b` and 15 `~b` produce the bitwise result in `result`. Opcodes 8 and 9 compute AND and XOR for flags only.
- R6: Arithmetic opcodes produce: 2 `a-b`, 3 `b-a`, 4 `a+b`, 5 `a+b+C`, 6 `a+~b+C`, 7 `b+~a+C`. Opcode 10 computes `a-b` and opcode 11 computes `a+b`, both for flags only.
- R7: For arithmetic opcodes with updates enabled: N is result bit 31, Z is high when the result is zero, C is the carry out of bit 31 of the inverted-operand addition, and V is high when both addends have equal sign bits and the result's sign differs from them.
- R8: For logical opcodes with updates enabled: N and Z follow the result, C is taken from `shift_cout`, and V keeps its input value.
- R9: Opcodes 8, 9, 10 and 11 never raise `wr_en`. Every other opcode raises `wr_en` when the condition passes.
- R10: When the condition fails, `wr_en` is low and `flags_out` equals the presented `flags_in`.
- R11: When `instr[20]` is low, `flags_out` equals the presented `flags_in`.
- R12: All three outputs change only on the clock edge that follows the inputs, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word (condition, opcode, set-flags bit) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Shifted second operand |
| shift_cout | input | 1 | Carry-out of the operand shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Registered operation result |
| wr_en | output | 1 | Registered destination write-enable |
| flags_out | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
`result`, `wr_en` and `flags_out` all come from a single register stage, so every result is due at the first rising edge after its inputs are driven. The bench drives inputs on the falling edge. It checks the value for the previous instruction just before the next rising edge. It checks the new value two nanoseconds after that edge, against a behavioural model computed from the same inputs. The condition table is swept over every flag combination, and every opcode is run against sign-boundary and carry-boundary operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSUB = 4'd3,
    OP_ADD = 4'd4,  OP_ADDC = 4'd5, OP_SUBC = 4'd6, OP_RSUBC = 4'd7,
    OP_TAND = 4'd8, OP_TXOR = 4'd9, OP_TSUB = 4'd10, OP_TADD = 4'd11,
    OP_OR  = 4'd12, OP_MOVE = 4'd13, OP_CLR = 4'd14, OP_NOT = 4'd15
  } alu_op_e;

  localparam int COND_LSB = 28;
  localparam int OPC_LSB  = 21;
  localparam int SETF_BIT = 20;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import alu_pkg::*;
(
  input  logic [3:0] code,
  input  flags_t     fl,
  output logic       pass
);
  logic base;

  always_comb begin
    unique case (code[3:1])
      3'd0: base = fl.z;
      3'd1: base = fl.c;
      3'd2: base = fl.n;
      3'd3: base = fl.v;
      3'd4: base = fl.c & ~fl.z;
      3'd5: base = ~(fl.n ^ fl.v);
      3'd6: base = ~fl.z & ~(fl.n ^ fl.v);
      default: base = 1'b1;
    endcase
    // odd codes are the complement of the even one below them
    pass = base ^ code[0];
  end

  // R4: the always code must pass, the never code must not
  always_comb begin
    a_r4_always_never : assert (!(code == 4'hE && !pass) && !(code == 4'hF && pass))
      else $error("condition 14/15 misdecoded");
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32
)(
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  flags_t       fl,
  input  logic         shift_cout,
  output logic [W-1:0] res,
  output flags_t       fl_new,
  output logic         flag_only
);
  localparam int MSB = W - 1;

  logic         arith;
  logic [W-1:0] add_x, add_y, logic_res;
  logic         add_cin;
  logic [W:0]   sum;
  logic         ovf;

  // operand steering: every subtract form becomes x + ~y + cin
  always_comb begin
    add_x   = a;
    add_y   = b;
    add_cin = 1'b0;
    arith   = 1'b1;
    unique case (op)
      OP_SUB, OP_TSUB: begin add_y = ~b; add_cin = 1'b1; end
      OP_RSUB:         begin add_x = b; add_y = ~a; add_cin = 1'b1; end
      OP_ADD, OP_TADD: add_cin = 1'b0;
      OP_ADDC:         add_cin = fl.c;
      OP_SUBC:         begin add_y = ~b; add_cin = fl.c; end
      OP_RSUBC:        begin add_x = b; add_y = ~a; add_cin = fl.c; end
      default:         arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
  assign ovf = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);

  always_comb begin
    unique case (op)
      OP_AND, OP_TAND: logic_res = a & b;
      OP_XOR, OP_TXOR: logic_res = a ^ b;
      OP_OR:           logic_res = a | b;
      OP_MOVE:         logic_res = b;
      OP_CLR:          logic_res = a & ~b;
      OP_NOT:          logic_res = ~b;
      default:         logic_res = '0;
    endcase
  end

  assign res       = arith ? sum[MSB:0] : logic_res;
  assign flag_only = (op == OP_TAND) || (op == OP_TXOR) || (op == OP_TSUB) || (op == OP_TADD);

  always_comb begin
    fl_new.n = res[MSB];
    fl_new.z = (res == '0);
    fl_new.c = arith ? sum[W] : shift_cout;
    fl_new.v = arith ? ovf : fl.v;
  end

  // R8: a logical op never alters V
  always_comb begin
    a_r8_logic_keeps_v : assert (arith || fl_new.v == fl.v)
      else $error("logical op changed V");
  end
endmodule

// File: rtl/cond_alu_stage.sv
module cond_alu_stage
  import alu_pkg::*;
#(
  parameter int W = 32
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [31:0]  instr,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_cout,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags_out
);
  flags_t       fl_cur, fl_calc;
  logic         pass, flag_only, set_flags;
  logic [W-1:0] alu_res;

  assign fl_cur    = flags_t'(flags_in);
  assign set_flags = instr[SETF_BIT];

  cond_eval u_cond (
    .code (instr[COND_LSB +: 4]),
    .fl   (fl_cur),
    .pass (pass)
  );

  alu_core #(.W(W)) u_alu (
    .op         (alu_op_e'(instr[OPC_LSB +: 4])),
    .a          (op_a),
    .b          (op_b),
    .fl         (fl_cur),
    .shift_cout (shift_cout),
    .res        (alu_res),
    .fl_new     (fl_calc),
    .flag_only  (flag_only)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
    end else begin
      result    <= alu_res;
      wr_en     <= pass & ~flag_only;
      flags_out <= (pass & set_flags) ? fl_calc : fl_cur;
    end
  end

  // R9: compare/test opcodes never write
  a_r9_test_no_write : assert property (@(posedge clk) disable iff (rst)
    (instr[24:23] == 2'b10) |=> !wr_en);

  // R10: failed condition holds flags and blocks the write
  a_r10_fail_holds : assert property (@(posedge clk) disable iff (rst)
    !pass |=> (!wr_en && flags_out == $past(flags_in)));

  // R11: set-flags bit low keeps the flags
  a_r11_nos_holds : assert property (@(posedge clk) disable iff (rst)
    !instr[SETF_BIT] |=> flags_out == $past(flags_in));

  // R4: never-condition blocks the write
  a_r4_never_no_write : assert property (@(posedge clk) disable iff (rst)
    (instr[31:28] == 4'hF) |=> !wr_en);
endmodule

// File: tb/sim_cond_alu_stage.sv
module sim_cond_alu_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0, op_a = '0, op_b = '0;
  logic        shift_cout = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] e_res = '0;
  logic        e_we = 1'b0;
  logic [3:0]  e_fl = '0;

  always #5 clk = ~clk;

  cond_alu_stage u0 (.clk(clk), .rst(rst), .instr(instr), .op_a(op_a), .op_b(op_b),
    .shift_cout(shift_cout), .flags_in(flags_in), .result(result), .wr_en(wr_en),
    .flags_out(flags_out));

  function automatic bit cond_ok(input int code, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (code)
      0: return z;      1: return !z;     2: return c;      3: return !c;
      4: return n;      5: return !n;     6: return v;      7: return !v;
      8: return c && !z;               9: return !c || z;
      10: return n == v;               11: return n != v;
      12: return !z && n == v;         13: return z || n != v;
      14: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] r, input logic w, input logic [3:0] f);
    checks++;
    if (result !== r || wr_en !== w || flags_out !== f) begin
      failures++;
      $display("FAIL %s: got res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
               tag, result, wr_en, flags_out, r, w, f);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] a,
                     input logic [31:0] b, input logic sc, input logic [3:0] f);
    longint unsigned x, y, s;
    logic [31:0] r;
    bit arith, pass;
    logic cin, cy, ov;
    int opc;
    @(negedge clk);
    instr = ins; op_a = a; op_b = b; shift_cout = sc; flags_in = f;
    #1 check("R12 hold", e_res, e_we, e_fl);
    opc = int'(ins[24:21]);
    pass = cond_ok(int'(ins[31:28]), f);
    arith = 1; x = a; y = b; cin = 0;
    case (opc)
      2, 10: begin y = ~b; cin = 1; end
      3: begin x = b; y = ~a; cin = 1; end
      4, 11: cin = 0;
      5: cin = f[1];
      6: begin y = ~b; cin = f[1]; end
      7: begin x = b; y = ~a; cin = f[1]; end
      default: arith = 0;
    endcase
    s = (x & 64'hFFFF_FFFF) + (y & 64'hFFFF_FFFF) + cin;
    if (arith) r = s[31:0];
    else case (opc)
      0, 8: r = a & b;   1, 9: r = a ^ b;   12: r = a | b;
      13: r = b;         14: r = a & ~b;    default: r = ~b;
    endcase
    cy = s[32];
    ov = (x[31] == y[31]) && (r[31] != x[31]);
    e_res = r;
    e_we = pass && !(opc >= 8 && opc <= 11);
    if (pass && ins[20]) e_fl = arith ? {r[31], r == 0, cy, ov} : {r[31], r == 0, sc, f[0]};
    else e_fl = f;
    @(posedge clk);
    #2 check(tag, e_res, e_we, e_fl);
  endtask

  function automatic logic [31:0] mk(input int cond, input int opc, input bit s);
    return {cond[3:0], 3'b000, opc[3:0], s, 20'h0};
  endfunction

  initial begin
    logic [31:0] va [6] = '{32'd5, 32'd3, 32'h7fffffff, 32'h80000000, 32'd0, 32'hffffffff};
    logic [31:0] vb [6] = '{32'd3, 32'd5, 32'd1, 32'h80000000, 32'd0, 32'd1};
    repeat (3) @(posedge clk);
    #2 check("R1 reset", 32'd0, 1'b0, 4'd0);
    @(negedge clk) rst = 1'b0;
    // R2 R3 R4 R10: condition sweep, MOV with flags set
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        run(c < 8 ? "R2 cond" : (c < 14 ? "R3 cond" : "R4 cond"),
            mk(c, 13, 1), 32'h1234, 32'h0, f[0], f[3:0]);
    // R5..R9: every opcode over boundary vectors and carry states
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 6; i++)
        for (int k = 0; k < 4; k++)
          run((o >= 8 && o <= 11) ? "R9 test-op" :
              ((o >= 2 && o <= 7) ? "R6 R7 arith" : "R5 R8 logic"),
              mk(14, o, 1), va[i], vb[i], k[0], {k[1], 1'b0, k[1], k[0]});
    // R11: no flag update when set-flags is low
    for (int o = 0; o < 16; o++)
      run("R11 no-s", mk(14, o, 0), 32'hffffffff, 32'd1, 1'b1, 4'b1010);
    // R10: failing condition on an arithmetic op
    run("R10 fail", mk(0, 4, 1), 32'hffffffff, 32'd1, 1'b0, 4'b0000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule